// File: doc/BRIEF.md
# Stream-to-Memory Descriptor DMA Engine

This block is the receive side of one DMA channel. Bytes arrive on a valid/ready stream that carries a packet-end marker. The block places them in memory through a word-wide request/acknowledge port. Where the bytes go is set by a chain of four-word descriptors. A pulse on `start_i` hands over the first descriptor's address and the address of the channel's context record. The engine reads the descriptor, fills its buffer from the buffer pointer upward, and closes the descriptor once the buffer is full or a packet ends.

When a descriptor closes, the engine writes two words back into it. The end-address word receives the address actually reached, so software can see how many bytes came in. The flag word gains a packet-end bit when the close was caused by a packet end. The engine also raises raw interrupt bits. If the descriptor is not the last in the chain, the engine fetches the one at its next pointer. If it is the last, the engine marks the context record as disabled, raises its end-of-list status and stops taking data until it is started again.

Descriptor layout, as byte offsets from the descriptor base:

| Offset | Content |
|--------|---------|
| +0 | next pointer |
| +4 | buffer start |
| +8 | flag word |
| +12 | end address (exclusive) |

Top module: `s2m_dma_engine`

## Requirements
- R1: Out of reset, `s_ready_o`, `mem_req_o`, `eol_o`, `busy_o` and `intr_raw_o` are all zero.
- R2: After `start_i`, the engine reads the descriptor words at base+0, +4, +8 and +12 in that order. `s_ready_o` is low during every descriptor read and every write-back. Each request holds its address until `mem_ack_i`.
- R3: Byte k of a descriptor goes to address buffer+k. It is placed in lane (address mod 4) of the aligned word, lane 0 being bits 7:0 (little-endian). A word is written when its lane 3 has been filled or when the descriptor closes. Only the lanes filled since the last write are strobed, so partial words occur at an unaligned start and at the end.
- R4: A descriptor takes at most end-minus-buffer bytes. It closes when the pointer reaches the end address, and `s_ready_o` is low in the cycle that follows.
- R5: A byte with `s_last_i` high closes the descriptor early, and the address one past that byte becomes the recorded end.
- R6: On close, the engine writes the flag word to base+8 and then the reached address to base+12. The flag word is the fetched word with bit 11 set if and only if the close came from a packet end; all other bits are unchanged.
- R7: On close, flag bit 4 sets raw interrupt bits 0 and 1, and a packet end sets raw bit 3. Bits already set stay set until cleared through `intr_clr_i` (write 1 to clear).
- R8: `intr_event_o` pulses for one cycle only when a close adds a raw bit that was not already set. A close that adds nothing produces no pulse.
- R9: If flag bit 0 (end-of-list) is clear after write-back, the engine fetches the descriptor at the next pointer. If it is set, the engine reads the context word at context+4, writes it back with bit 15 set, and then raises `eol_o`.
- R10: While `eol_o` is high, `s_ready_o` stays low and no memory write occurs. A new `start_i` clears `eol_o` and starts a new chain.
- R11: A descriptor whose buffer start equals its end closes right after its fetch without accepting any byte. It writes its start address back as its end.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | clock |
| rst_n | input | 1 | active-low asynchronous reset |
| start_i | input | 1 | begin a chain; accepted when not busy |
| desc_addr_i | input | AW | address of the first descriptor |
| ctx_addr_i | input | AW | address of the context record |
| s_valid_i | input | 1 | stream byte valid |
| s_data_i | input | 8 | stream byte |
| s_last_i | input | 1 | byte ends a packet |
| s_ready_o | output | 1 | stream byte accepted this cycle |
| mem_req_o | output | 1 | memory request, held until acknowledged |
| mem_we_o | output | 1 | 1 write, 0 read |
| mem_addr_o | output | AW | word-aligned byte address |
| mem_wdata_o | output | 32 | write data |
| mem_be_o | output | 4 | write byte strobes |
| mem_ack_i | input | 1 | request completed; read data valid |
| mem_rdata_i | input | 32 | read data |
| intr_clr_i | input | 4 | clear raw interrupt bits |
| intr_raw_o | output | 4 | raw interrupt bits |
| intr_event_o | output | 1 | raw interrupt value changed by a close |
| eol_o | output | 1 | end of list reached |
| busy_o | output | 1 | chain in progress |

## Verification
The tests run a chain of five descriptors. The first starts at an odd address with no packet end, which separates the leading, middle and trailing strobe patterns from a close caused by a full buffer. The second ends a packet early inside a large buffer, which separates the recorded end and the bit-11 flag from the full-buffer case. The third is zero-length while its interrupt bits are already raised, which shows that a close without a change gives no event. The chain then stops at end-of-list with data still offered, so the context write and a frozen stream can be told apart from a continued run. A fifth descriptor, started after that stop, checks that the engine restarts cleanly.

// File: rtl/s2m_pkg.sv
package s2m_pkg;
    localparam int WORD_LANES   = 4;
    localparam int WORD_BITS    = WORD_LANES * 8;

    // descriptor word offsets in bytes
    localparam int OFS_NEXT     = 0;
    localparam int OFS_FLAGS    = 8;
    localparam int OFS_END      = 12;
    localparam int CTX_OFS_CTRL = 4;
    localparam int FETCH_WORDS  = 4;

    // flag word bit positions
    localparam int FLG_LAST     = 0;
    localparam int FLG_IRQ      = 4;
    localparam int FLG_PKT_END  = 11;
    localparam int CTX_OFF_BIT  = 15;

    // raw interrupt vector
    localparam int RAW_BITS     = 4;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_FETCH,
        ST_DATA,
        ST_FLUSH,
        ST_WB_FLAGS,
        ST_WB_END,
        ST_CTX_RD,
        ST_CTX_WR,
        ST_HALT
    } eng_state_e;
endpackage

// File: rtl/s2m_byte_packer.sv
module s2m_byte_packer #(
    parameter int LANES = 4,
    localparam int LB   = $clog2(LANES)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               take_i,
    input  logic [LB-1:0]      lane_i,
    input  logic [7:0]         byte_i,
    input  logic               clear_i,
    output logic [LANES*8-1:0] word_o,
    output logic [LANES-1:0]   be_o
);
    typedef struct packed {
        logic [LANES*8-1:0] word;
        logic [LANES-1:0]   be;
    } pk_t;

    pk_t pk_d, pk_q;
    logic [LANES-1:0] hit;

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        assign hit[g] = take_i && (lane_i == LB'(g));
    end

    always_comb begin
        pk_d = pk_q;
        if (clear_i) begin
            pk_d.word = '0;
            pk_d.be   = '0;
        end
        for (int i = 0; i < LANES; i++) begin
            if (hit[i]) begin
                pk_d.word[i*8 +: 8] = byte_i;
                pk_d.be[i]          = 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) pk_q <= '0;
        else        pk_q <= pk_d;
    end

    assign word_o = pk_q.word;
    assign be_o   = pk_q.be;
endmodule

// File: rtl/s2m_irq_raw.sv
module s2m_irq_raw #(
    parameter int NB = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [NB-1:0] set_i,
    input  logic [NB-1:0] clr_i,
    output logic [NB-1:0] raw_o,
    output logic          event_o
);
    typedef struct packed {
        logic [NB-1:0] raw;
        logic          evt;
    } irq_t;

    irq_t ir_d, ir_q;

    always_comb begin
        ir_d     = ir_q;
        ir_d.raw = (ir_q.raw & ~clr_i) | set_i;
        ir_d.evt = |(set_i & ~ir_q.raw);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) ir_q <= '0;
        else        ir_q <= ir_d;
    end

    assign raw_o   = ir_q.raw;
    assign event_o = ir_q.evt;
endmodule

// File: rtl/s2m_dma_engine.sv
module s2m_dma_engine
    import s2m_pkg::*;
#(
    parameter int AW = 32
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 start_i,
    input  logic [AW-1:0]        desc_addr_i,
    input  logic [AW-1:0]        ctx_addr_i,
    input  logic                 s_valid_i,
    input  logic [7:0]           s_data_i,
    input  logic                 s_last_i,
    output logic                 s_ready_o,
    output logic                 mem_req_o,
    output logic                 mem_we_o,
    output logic [AW-1:0]        mem_addr_o,
    output logic [WORD_BITS-1:0] mem_wdata_o,
    output logic [WORD_LANES-1:0] mem_be_o,
    input  logic                 mem_ack_i,
    input  logic [WORD_BITS-1:0] mem_rdata_i,
    input  logic [RAW_BITS-1:0]  intr_clr_i,
    output logic [RAW_BITS-1:0]  intr_raw_o,
    output logic                 intr_event_o,
    output logic                 eol_o,
    output logic                 busy_o
);
    localparam int LB = $clog2(WORD_LANES);
    localparam int IW = $clog2(FETCH_WORDS);

    typedef struct packed {
        eng_state_e           st;
        logic [IW-1:0]        idx;
        logic [AW-1:0]        dptr;
        logic [AW-1:0]        cptr;
        logic [AW-1:0]        nxt;
        logic [AW-1:0]        bptr;
        logic [AW-1:0]        endp;
        logic [WORD_BITS-1:0] flags;
        logic [WORD_BITS-1:0] ctxw;
        logic                 close_pend;
        logic                 eop_pend;
        logic                 eol;
    } eng_t;

    eng_t cs_d, cs_q;

    logic                  pk_take, pk_clear;
    logic [WORD_BITS-1:0]  pk_word;
    logic [WORD_LANES-1:0] pk_be;
    logic                  close_now, close_eop;
    logic [RAW_BITS-1:0]   irq_set;
    logic [AW-1:0]         bptr_inc;
    logic [AW-1:0]         last_byte;

    assign bptr_inc  = cs_q.bptr + AW'(1);
    assign last_byte = cs_q.bptr - AW'(1);

    always_comb begin
        cs_d        = cs_q;
        s_ready_o   = 1'b0;
        mem_req_o   = 1'b0;
        mem_we_o    = 1'b0;
        mem_addr_o  = '0;
        mem_wdata_o = '0;
        mem_be_o    = '0;
        pk_take     = 1'b0;
        pk_clear    = 1'b0;
        close_now   = 1'b0;
        close_eop   = 1'b0;
        irq_set     = '0;

        unique case (cs_q.st)
            ST_IDLE, ST_HALT: begin
                if (start_i) begin
                    cs_d.dptr = desc_addr_i;
                    cs_d.cptr = ctx_addr_i;
                    cs_d.idx  = '0;
                    cs_d.eol  = 1'b0;
                    cs_d.st   = ST_FETCH;
                end
            end
            ST_FETCH: begin
                mem_req_o  = 1'b1;
                mem_addr_o = cs_q.dptr + AW'({cs_q.idx, 2'b00});
                if (mem_ack_i) begin
                    unique case (cs_q.idx)
                        2'd0:    cs_d.nxt   = mem_rdata_i[AW-1:0];
                        2'd1:    cs_d.bptr  = mem_rdata_i[AW-1:0];
                        2'd2:    cs_d.flags = mem_rdata_i;
                        default: cs_d.endp  = mem_rdata_i[AW-1:0];
                    endcase
                    cs_d.idx = cs_q.idx + IW'(1);
                    if (cs_q.idx == IW'(FETCH_WORDS - 1)) begin
                        if (cs_q.bptr == mem_rdata_i[AW-1:0]) close_now = 1'b1;
                        else                                  cs_d.st   = ST_DATA;
                    end
                end
            end
            ST_DATA: begin
                s_ready_o = 1'b1;
                if (s_valid_i) begin
                    pk_take   = 1'b1;
                    cs_d.bptr = bptr_inc;
                    if ((cs_q.bptr[LB-1:0] == LB'(WORD_LANES - 1)) ||
                        (bptr_inc == cs_q.endp) || s_last_i) begin
                        cs_d.st         = ST_FLUSH;
                        cs_d.close_pend = (bptr_inc == cs_q.endp) || s_last_i;
                        cs_d.eop_pend   = s_last_i;
                    end
                end
            end
            ST_FLUSH: begin
                mem_req_o   = 1'b1;
                mem_we_o    = 1'b1;
                mem_addr_o  = {last_byte[AW-1:LB], LB'(0)};
                mem_wdata_o = pk_word;
                mem_be_o    = pk_be;
                if (mem_ack_i) begin
                    pk_clear = 1'b1;
                    if (cs_q.close_pend) begin
                        close_now = 1'b1;
                        close_eop = cs_q.eop_pend;
                    end else begin
                        cs_d.st = ST_DATA;
                    end
                end
            end
            ST_WB_FLAGS: begin
                mem_req_o   = 1'b1;
                mem_we_o    = 1'b1;
                mem_addr_o  = cs_q.dptr + AW'(OFS_FLAGS);
                mem_wdata_o = cs_q.flags;
                mem_be_o    = '1;
                if (mem_ack_i) cs_d.st = ST_WB_END;
            end
            ST_WB_END: begin
                mem_req_o   = 1'b1;
                mem_we_o    = 1'b1;
                mem_addr_o  = cs_q.dptr + AW'(OFS_END);
                mem_wdata_o = WORD_BITS'(cs_q.endp);
                mem_be_o    = '1;
                if (mem_ack_i) begin
                    if (cs_q.flags[FLG_LAST]) begin
                        cs_d.st = ST_CTX_RD;
                    end else begin
                        cs_d.dptr = cs_q.nxt;
                        cs_d.idx  = '0;
                        cs_d.st   = ST_FETCH;
                    end
                end
            end
            ST_CTX_RD: begin
                mem_req_o  = 1'b1;
                mem_addr_o = cs_q.cptr + AW'(CTX_OFS_CTRL);
                if (mem_ack_i) begin
                    cs_d.ctxw              = mem_rdata_i;
                    cs_d.ctxw[CTX_OFF_BIT] = 1'b1;
                    cs_d.st                = ST_CTX_WR;
                end
            end
            ST_CTX_WR: begin
                mem_req_o   = 1'b1;
                mem_we_o    = 1'b1;
                mem_addr_o  = cs_q.cptr + AW'(CTX_OFS_CTRL);
                mem_wdata_o = cs_q.ctxw;
                mem_be_o    = '1;
                if (mem_ack_i) begin
                    cs_d.eol = 1'b1;
                    cs_d.st  = ST_HALT;
                end
            end
            default: cs_d.st = ST_IDLE;
        endcase

        if (close_now) begin
            if (close_eop) cs_d.flags[FLG_PKT_END] = 1'b1;
            cs_d.endp       = cs_d.bptr;
            cs_d.close_pend = 1'b0;
            cs_d.eop_pend   = 1'b0;
            cs_d.st         = ST_WB_FLAGS;
            irq_set         = {close_eop, 1'b0, cs_d.flags[FLG_IRQ], cs_d.flags[FLG_IRQ]};
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cs_q    <= '0;
            cs_q.st <= ST_IDLE;
        end else begin
            cs_q <= cs_d;
        end
    end

    s2m_byte_packer #(.LANES(WORD_LANES)) u_pack (
        .clk     (clk),
        .rst_n   (rst_n),
        .take_i  (pk_take),
        .lane_i  (cs_q.bptr[LB-1:0]),
        .byte_i  (s_data_i),
        .clear_i (pk_clear),
        .word_o  (pk_word),
        .be_o    (pk_be)
    );

    s2m_irq_raw #(.NB(RAW_BITS)) u_irq (
        .clk     (clk),
        .rst_n   (rst_n),
        .set_i   (irq_set),
        .clr_i   (intr_clr_i),
        .raw_o   (intr_raw_o),
        .event_o (intr_event_o)
    );

    assign eol_o  = cs_q.eol;
    assign busy_o = (cs_q.st != ST_IDLE) && (cs_q.st != ST_HALT);
endmodule

// File: rtl/s2m_dma_checker.sv
module s2m_dma_checker #(
    parameter int AW = 32
) (
    input logic          clk,
    input logic          rst_n,
    input logic          s_ready_o,
    input logic          mem_req_o,
    input logic          mem_we_o,
    input logic          mem_ack_i,
    input logic [AW-1:0] mem_addr_o,
    input logic [3:0]    mem_be_o,
    input logic [3:0]    intr_raw_o,
    input logic          intr_event_o,
    input logic          eol_o
);
    // R2: no stream acceptance while a memory access is pending
    p_ready_vs_mem_r2: assert property (@(posedge clk) disable iff (!rst_n)
        s_ready_o |-> !mem_req_o);

    // R2: a request holds its address until acknowledged
    p_req_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req_o && !mem_ack_i) |=> (mem_req_o && $stable(mem_addr_o)));

    // R3: word aligned addresses and non-empty strobes on writes
    p_aligned_r3: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req_o |-> (mem_addr_o[1:0] == 2'b00));

    p_strobe_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req_o && mem_we_o) |-> (mem_be_o != 4'b0000));

    // R7: a raw bit can only appear together with the event pulse
    p_raw_rise_r7: assert property (@(posedge clk) disable iff (!rst_n)
        ((intr_raw_o & ~$past(intr_raw_o)) != 4'b0000) |-> intr_event_o);

    // R8: an event pulse always comes with a changed raw value
    p_event_change_r8: assert property (@(posedge clk) disable iff (!rst_n)
        intr_event_o |-> (intr_raw_o != $past(intr_raw_o)));

    // R9: end of list is entered only through an acknowledged write
    p_eol_entry_r9: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(eol_o) |-> $past(mem_req_o && mem_we_o && mem_ack_i));

    // R10: halted engine never offers ready
    p_halt_quiet_r10: assert property (@(posedge clk) disable iff (!rst_n)
        eol_o |-> (!s_ready_o && !mem_req_o));
endmodule

bind s2m_dma_engine s2m_dma_checker #(.AW(AW)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .s_ready_o    (s_ready_o),
    .mem_req_o    (mem_req_o),
    .mem_we_o     (mem_we_o),
    .mem_ack_i    (mem_ack_i),
    .mem_addr_o   (mem_addr_o),
    .mem_be_o     (mem_be_o),
    .intr_raw_o   (intr_raw_o),
    .intr_event_o (intr_event_o),
    .eol_o        (eol_o)
);

// File: tb/s2m_dma_engine_tb.sv
module s2m_dma_engine_tb;
    localparam int CLK_PERIOD = 10;
    localparam int AW = 32;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #(CLK_PERIOD/2) clk = ~clk;

    logic          start_i = 1'b0;
    logic [AW-1:0] desc_addr_i = '0, ctx_addr_i = '0;
    logic          s_valid_i = 1'b0, s_last_i = 1'b0;
    logic [7:0]    s_data_i = '0;
    logic          s_ready_o;
    logic          mem_req_o, mem_we_o, mem_ack_i;
    logic [AW-1:0] mem_addr_o;
    logic [31:0]   mem_wdata_o, mem_rdata_i;
    logic [3:0]    mem_be_o;
    logic [3:0]    intr_clr_i = '0, intr_raw_o;
    logic          intr_event_o, eol_o, busy_o;

    s2m_dma_engine #(.AW(AW)) u_dut (
        .clk(clk), .rst_n(rst_n), .start_i(start_i),
        .desc_addr_i(desc_addr_i), .ctx_addr_i(ctx_addr_i),
        .s_valid_i(s_valid_i), .s_data_i(s_data_i), .s_last_i(s_last_i),
        .s_ready_o(s_ready_o), .mem_req_o(mem_req_o), .mem_we_o(mem_we_o),
        .mem_addr_o(mem_addr_o), .mem_wdata_o(mem_wdata_o), .mem_be_o(mem_be_o),
        .mem_ack_i(mem_ack_i), .mem_rdata_i(mem_rdata_i),
        .intr_clr_i(intr_clr_i), .intr_raw_o(intr_raw_o),
        .intr_event_o(intr_event_o), .eol_o(eol_o), .busy_o(busy_o)
    );

    typedef struct {
        logic [31:0] a;
        logic [31:0] d;
        logic [3:0]  be;
        string       rq;
    } wr_t;

    logic [31:0] mem [0:511];
    wr_t exp_q[$];
    int  n_chk = 0, n_bad = 0, ev_cnt = 0;
    bit  done = 1'b0;

    task automatic chk(input string rq, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s: actual=%h expected=%h", rq, what, act, exp);
        end
    endtask

    // memory model and scoreboard monitor
    initial begin
        mem_ack_i   = 1'b0;
        mem_rdata_i = '0;
        forever begin
            @(posedge clk);
            if (intr_event_o) ev_cnt++;
            if (rst_n && mem_req_o && !mem_ack_i) begin
                if (mem_we_o) begin
                    logic [31:0] mask;
                    mask = '0;
                    for (int b = 0; b < 4; b++) begin
                        if (mem_be_o[b]) begin
                            mem[mem_addr_o[10:2]][b*8 +: 8] = mem_wdata_o[b*8 +: 8];
                            mask[b*8 +: 8] = 8'hFF;
                        end
                    end
                    if (exp_q.size() == 0) begin
                        chk("R10", "unexpected write address", mem_addr_o, 32'hFFFF_FFFF);
                    end else begin
                        wr_t e;
                        e = exp_q.pop_front();
                        chk(e.rq, "write address", mem_addr_o, e.a);
                        chk(e.rq, "write strobes", {28'b0, mem_be_o}, {28'b0, e.be});
                        chk(e.rq, "write data", mem_wdata_o & mask, e.d & mask);
                    end
                end else begin
                    mem_rdata_i <= mem[mem_addr_o[10:2]];
                end
                mem_ack_i <= 1'b1;
            end else begin
                mem_ack_i <= 1'b0;
            end
        end
    end

    task automatic push(input logic [31:0] a, input logic [31:0] d,
                        input logic [3:0] be, input string rq);
        wr_t e;
        e.a = a; e.d = d; e.be = be; e.rq = rq;
        exp_q.push_back(e);
    endtask

    // expected packed data words, little-endian lanes by address
    task automatic exp_data(input logic [31:0] bufa, input int n,
                            input logic [7:0] base, input string rq);
        logic [31:0] w;
        logic [3:0]  b;
        w = '0; b = '0;
        for (int k = 0; k < n; k++) begin
            logic [31:0] a;
            a = bufa + k;
            w[a[1:0]*8 +: 8] = base + 8'(k);
            b[a[1:0]] = 1'b1;
            if (a[1:0] == 2'd3 || k == n - 1) begin
                push({a[31:2], 2'b00}, w, b, rq);
                w = '0; b = '0;
            end
        end
    endtask

    task automatic exp_wb(input logic [31:0] d, input logic [31:0] flags,
                          input logic [31:0] endp, input string rq);
        push(d + 8, flags, 4'hF, rq);
        push(d + 12, endp, 4'hF, rq);
    endtask

    task automatic set_desc(input logic [31:0] d, input logic [31:0] nxt,
                            input logic [31:0] bufa, input logic [31:0] flags,
                            input logic [31:0] endp);
        mem[d[10:2]]     = nxt;
        mem[d[10:2] + 1] = bufa;
        mem[d[10:2] + 2] = flags;
        mem[d[10:2] + 3] = endp;
    endtask

    task automatic send(input int n, input logic [7:0] base, input bit eop);
        for (int k = 0; k < n; k++) begin
            @(negedge clk);
            s_valid_i = 1'b1;
            s_data_i  = base + 8'(k);
            s_last_i  = eop && (k == n - 1);
            while (!s_ready_o) @(negedge clk);
        end
        @(negedge clk);
        s_valid_i = 1'b0;
        s_last_i  = 1'b0;
    endtask

    task automatic kick(input logic [31:0] d, input logic [31:0] c);
        @(negedge clk);
        start_i = 1'b1; desc_addr_i = d; ctx_addr_i = c;
        @(negedge clk);
        start_i = 1'b0;
    endtask

    task automatic wait_quiet();
        int t;
        t = 0;
        while (!(exp_q.size() == 0 && s_ready_o && !mem_req_o) && t < 2000) begin
            @(negedge clk);
            t++;
        end
    endtask

    task automatic wait_eol();
        int t;
        t = 0;
        while (!(exp_q.size() == 0 && eol_o) && t < 2000) begin
            @(negedge clk);
            t++;
        end
    endtask

    task automatic summary();
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            summary();
            $finish;
        end
    end

    initial begin
        for (int i = 0; i < 512; i++) mem[i] = '0;
        mem[32'h84 >> 2] = 32'h0000_1234;
        set_desc(32'h100, 32'h140, 32'h201, 32'h10,  32'h20A);
        set_desc(32'h140, 32'h180, 32'h300, 32'h00,  32'h340);
        set_desc(32'h180, 32'h1C0, 32'h380, 32'h10,  32'h380);
        set_desc(32'h1C0, 32'h000, 32'h3C0, 32'h01,  32'h3C8);
        set_desc(32'h1E0, 32'h000, 32'h3E2, 32'h11,  32'h3E4);

        repeat (3) @(negedge clk);
        // R1: reset state
        chk("R1", "ready in reset", {31'b0, s_ready_o}, 32'd0);
        chk("R1", "req in reset", {31'b0, mem_req_o}, 32'd0);
        chk("R1", "eol/busy in reset", {30'b0, eol_o, busy_o}, 32'd0);
        chk("R1", "raw in reset", {28'b0, intr_raw_o}, 32'd0);
        rst_n = 1'b1;

        // descriptor 1: unaligned start, fills completely
        exp_data(32'h201, 9, 8'h10, "R3");
        exp_wb(32'h100, 32'h10, 32'h20A, "R6");
        kick(32'h100, 32'h80);
        // R2: first access is the read of descriptor word 0, ready held low
        chk("R2", "fetch request", {30'b0, mem_req_o, mem_we_o}, 32'b10);
        chk("R2", "fetch address", mem_addr_o, 32'h100);
        chk("R2", "ready during fetch", {31'b0, s_ready_o}, 32'd0);
        send(9, 8'h10, 1'b0);
        // R4: buffer full, no further byte taken
        chk("R4", "ready after full buffer", {31'b0, s_ready_o}, 32'd0);
        wait_quiet();
        chk("R7", "raw after interrupting close", {28'b0, intr_raw_o}, 32'h3);
        chk("R8", "event count after first close", ev_cnt, 32'd1);

        // descriptor 2: early packet end; descriptor 3: zero length
        exp_data(32'h300, 5, 8'h40, "R5");
        exp_wb(32'h140, 32'h800, 32'h305, "R5");
        exp_wb(32'h180, 32'h10, 32'h380, "R11");
        send(5, 8'h40, 1'b1);
        wait_quiet();
        chk("R7", "raw after packet end", {28'b0, intr_raw_o}, 32'hB);
        chk("R8", "no event for unchanged raw", ev_cnt, 32'd2);
        chk("R9", "chained to descriptor 4", {31'b0, busy_o}, 32'd1);

        // clear raw bits
        @(negedge clk);
        intr_clr_i = 4'hF;
        @(negedge clk);
        intr_clr_i = 4'h0;
        chk("R7", "raw after clear", {28'b0, intr_raw_o}, 32'h0);

        // descriptor 4: end of list with packet end
        exp_data(32'h3C0, 3, 8'h70, "R3");
        exp_wb(32'h1C0, 32'h801, 32'h3C3, "R6");
        push(32'h84, 32'h0000_9234, 4'hF, "R9");
        send(3, 8'h70, 1'b1);
        wait_eol();
        chk("R9", "eol raised", {31'b0, eol_o}, 32'd1);
        chk("R9", "context word", mem[32'h84 >> 2], 32'h0000_9234);
        chk("R8", "event for packet end", ev_cnt, 32'd3);
        chk("R7", "raw packet end only", {28'b0, intr_raw_o}, 32'h8);

        // R10: data offered while halted is not taken
        begin
            int seen;
            seen = 0;
            @(negedge clk);
            s_valid_i = 1'b1; s_data_i = 8'hEE;
            for (int i = 0; i < 10; i++) begin
                @(negedge clk);
                if (s_ready_o) seen++;
            end
            s_valid_i = 1'b0;
            chk("R10", "ready cycles while halted", seen, 32'd0);
        end
        chk("R10", "no pending writes while halted", exp_q.size(), 32'd0);

        // restart on descriptor 5
        exp_data(32'h3E2, 2, 8'hA0, "R3");
        exp_wb(32'h1E0, 32'h11, 32'h3E4, "R4");
        push(32'h84, 32'h0000_9234, 4'hF, "R9");
        kick(32'h1E0, 32'h80);
        chk("R10", "eol cleared by restart", {31'b0, eol_o}, 32'd0);
        send(2, 8'hA0, 1'b0);
        wait_eol();
        chk("R10", "eol after second chain", {31'b0, eol_o}, 32'd1);
        chk("R7", "raw after restart close", {28'b0, intr_raw_o}, 32'hB);
        chk("R8", "event count final", ev_cnt, 32'd4);
        chk("R6", "recorded end in memory", mem[32'h1EC >> 2], 32'h3E4);

        repeat (5) @(negedge clk);
        done = 1'b1;
        summary();
        $finish;
    end
endmodule